// File: doc/BRIEF.md
# Secondary Cache Read Dispatcher

This block sits beside a processor system bus and decides, for every read the processor puts on that bus, whether the system controller has to serve it. It decodes the command field to sort each read into one of two kinds. An uncacheable (partial) read goes straight to the system controller after a fixed one-cycle delay. A cacheable (block) read is first checked against an external tag memory.

For a block read, the block samples the tag compare result in the cycle after the processor's valid strobe is first seen. It reports a hit early, so that outside logic can act on it. It pulses a bus-release strobe two cycles after the issue cycle. The issue cycle is the first cycle of the request in which read-ready is asserted. One cycle after the release pulse, the block forwards the request to the system controller, but only if the lookup missed. On a hit, the data comes from the secondary cache and nothing is forwarded.

Only one read is handled at a time. All strobes are active-low and come straight from flip-flops. Reset is synchronous and active-high.

Top module: `scd_read_dispatch`

## Requirements
- R1: While reset is high at a clock edge, all three outputs are high (deasserted) in the next cycle and any request in progress is dropped, so a read presented in the first cycle after reset is accepted.
- R2: A command is a read only when bit 8 is 0 and bits 7:5 are 000. Among reads, bit 3 = 1 marks a partial read and bit 3 = 0 marks a block read. Any other command, presented with the valid strobe low, causes no output to go low.
- R3: For a partial read, the forwarded valid strobe is low for exactly one cycle, in the cycle after the issue cycle. Hit and bus-release stay high throughout.
- R4: The issue cycle is the first cycle of a request in which read-ready is low. When read-ready is already low in the cycle the valid strobe is first seen, that same cycle is the issue cycle. The processor holds its valid strobe and command until the issue cycle.
- R5: For a block read, the tag compare input is sampled only in the cycle after the valid strobe is first seen. Its value in every other cycle has no effect on the outputs.
- R6: On a block-read hit, the hit output is low from the second cycle after the valid strobe is first seen, through the bus-release cycle, and high after that. On a miss, it stays high.
- R7: For a block read, the bus-release strobe is low for exactly one cycle, two cycles after the issue cycle. It is never low in the same cycle as the forwarded valid strobe.
- R8: For a block read that missed, the forwarded valid strobe is low for exactly one cycle, three cycles after the issue cycle. On a hit it stays high.
- R9: A valid strobe seen while a read is in progress is ignored. A new request is accepted from two cycles after the issue cycle for a partial read, three cycles for a block hit, and four cycles for a block miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sys_cmd_i | input | CMD_W (9) | Processor command field |
| cpu_valid_n_i | input | 1 | Processor valid strobe, active low |
| rd_ready_n_i | input | 1 | Read-ready, active low; marks the issue cycle |
| tag_match_i | input | 1 | Tag compare result from external tag memory, active high |
| hit_n_o | output | 1 | Block-read hit indication, active low |
| fwd_valid_n_o | output | 1 | Request forwarded to system controller, active low |
| bus_release_n_o | output | 1 | Processor bus released, active low |

## Verification
The bench builds the block with its default 9-bit command field, which is small enough to sweep every command code. Each code is crossed with read-ready delays of zero to three cycles and with both tag outcomes. The tag input is driven with the opposite value in every cycle except the lookup cycle, so a lookup in the wrong cycle shows up on the hit and forward outputs. Directed sequences then present requests while a read is busy, present a request in the first free cycle after each kind of read, and assert reset in the middle of a block read.

// File: rtl/scd_pkg.sv
package scd_pkg;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_PARTIAL = 2'd1,
        KIND_BLOCK   = 2'd2
    } rd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PWAIT  = 3'd1,
        ST_PFWD   = 3'd2,
        ST_LOOK   = 3'd3,
        ST_WISSUE = 3'd4,
        ST_ISSUE  = 3'd5,
        ST_REL    = 3'd6,
        ST_FWD    = 3'd7
    } seq_state_e;

    // Desired levels of the outgoing strobes, active high inside the block.
    typedef struct packed {
        logic hit;
        logic rel;
        logic fwd;
    } strobe_set_t;

    localparam int STROBE_N = $bits(strobe_set_t);

    function automatic strobe_set_t strobes_idle();
        strobe_set_t s;
        s.hit = 1'b0;
        s.rel = 1'b0;
        s.fwd = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/scd_cmd_decode.sv
module scd_cmd_decode
    import scd_pkg::*;
#(
    parameter int CMD_W     = 9,
    parameter int FLAG_BIT  = 8,
    parameter int OP_LSB    = 5,
    parameter int OP_W      = 3,
    parameter int SIZE_BIT  = 3
) (
    input  logic [CMD_W-1:0] cmd,
    output rd_kind_e         kind
);
    localparam int OP_MSB = OP_LSB + OP_W - 1;

    logic [OP_W-1:0] op_zero_chain;

    // Ripple a zero test across the opcode field.
    genvar g;
    generate
        for (g = 0; g < OP_W; g++) begin : g_opz
            if (g == 0) begin : g_first
                assign op_zero_chain[g] = ~cmd[OP_LSB];
            end else begin : g_next
                assign op_zero_chain[g] = op_zero_chain[g-1] & ~cmd[OP_LSB+g];
            end
        end
    endgenerate

    logic is_read;
    assign is_read = ~cmd[FLAG_BIT] & op_zero_chain[OP_W-1];

    always_comb begin
        if (!is_read)           kind = KIND_NONE;
        else if (cmd[SIZE_BIT]) kind = KIND_PARTIAL;
        else                    kind = KIND_BLOCK;
    end

    logic unused_cmd;
    assign unused_cmd = ^{cmd, OP_MSB[0]};

endmodule

// File: rtl/scd_sequencer.sv
module scd_sequencer
    import scd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  rd_kind_e    req_kind,
    input  logic        rd_ready,
    input  logic        tag_match,
    output strobe_set_t strobe_nxt
);
    seq_state_e state_q, state_d;
    logic       issued_q, issued_d;
    logic       hit_q, hit_d;

    logic start;
    assign start = (state_q == ST_IDLE) && req_valid && (req_kind != KIND_NONE);

    always_comb begin
        state_d    = state_q;
        issued_d   = issued_q;
        hit_d      = hit_q;
        strobe_nxt = strobes_idle();
        unique case (state_q)
            ST_IDLE: begin
                issued_d = 1'b0;
                hit_d    = 1'b0;
                if (start && req_kind == KIND_PARTIAL) begin
                    if (rd_ready) begin
                        strobe_nxt.fwd = 1'b1;
                        state_d        = ST_PFWD;
                    end else begin
                        state_d = ST_PWAIT;
                    end
                end else if (start) begin
                    issued_d = rd_ready;
                    state_d  = ST_LOOK;
                end
            end
            ST_PWAIT: begin
                if (rd_ready) begin
                    strobe_nxt.fwd = 1'b1;
                    state_d        = ST_PFWD;
                end
            end
            ST_PFWD: begin
                state_d = ST_IDLE;
            end
            ST_LOOK: begin
                hit_d          = tag_match;
                strobe_nxt.hit = tag_match;
                if (issued_q) begin
                    strobe_nxt.rel = 1'b1;
                    state_d        = ST_REL;
                end else if (rd_ready) begin
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_WISSUE;
                end
            end
            ST_WISSUE: begin
                strobe_nxt.hit = hit_q;
                if (rd_ready) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                strobe_nxt.hit = hit_q;
                strobe_nxt.rel = 1'b1;
                state_d        = ST_REL;
            end
            ST_REL: begin
                if (!hit_q) begin
                    strobe_nxt.fwd = 1'b1;
                    state_d        = ST_FWD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_FWD: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
            hit_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            issued_q <= issued_d;
            hit_q    <= hit_d;
        end
    end

    AST_BLOCK_TO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req_valid && req_kind == KIND_BLOCK) |=> (state_q == ST_LOOK)) else $error("AST_BLOCK_TO_LOOKUP"); // R5
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REL) |=> (state_q == ST_IDLE || state_q == ST_FWD)) else $error("AST_BUSY_IGNORES"); // R9
    AST_PARTIAL_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PWAIT || state_q == ST_PFWD) |-> !strobe_nxt.rel && !strobe_nxt.hit) else $error("AST_PARTIAL_BYPASS"); // R3

endmodule

// File: rtl/scd_strobe_out.sv
module scd_strobe_out
    import scd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  strobe_set_t strobe_nxt,
    output logic        hit_n,
    output logic        rel_n,
    output logic        fwd_n
);
    logic [STROBE_N-1:0] nxt_vec;
    logic [STROBE_N-1:0] out_n_q;

    assign nxt_vec = strobe_nxt;

    genvar g;
    generate
        for (g = 0; g < STROBE_N; g++) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) out_n_q[g] <= 1'b1;
                else     out_n_q[g] <= ~nxt_vec[g];
            end
        end
    endgenerate

    assign {hit_n, rel_n, fwd_n} = out_n_q;

    AST_REL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !rel_n |=> rel_n) else $error("AST_REL_SINGLE"); // R7
    AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !fwd_n |=> fwd_n) else $error("AST_FWD_SINGLE"); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(!rel_n && !fwd_n)) else $error("AST_NO_OVERLAP"); // R7
    AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!hit_n && rel_n) |=> !hit_n) else $error("AST_HIT_HOLDS"); // R6
    AST_HIT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!hit_n && !rel_n) |=> hit_n) else $error("AST_HIT_DROPS"); // R6
    AST_HIT_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        (!hit_n && !rel_n) |=> fwd_n) else $error("AST_HIT_NO_FWD"); // R8
    AST_MISS_FWD: assert property (@(posedge clk) disable iff (rst)
        (hit_n && !rel_n) |=> !fwd_n) else $error("AST_MISS_FWD"); // R8

endmodule

// File: rtl/scd_read_dispatch.sv
module scd_read_dispatch
    import scd_pkg::*;
#(
    parameter int CMD_W    = 9,
    parameter int FLAG_BIT = 8,
    parameter int OP_LSB   = 5,
    parameter int OP_W     = 3,
    parameter int SIZE_BIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] sys_cmd_i,
    input  logic             cpu_valid_n_i,
    input  logic             rd_ready_n_i,
    input  logic             tag_match_i,
    output logic             hit_n_o,
    output logic             fwd_valid_n_o,
    output logic             bus_release_n_o
);
    rd_kind_e    kind;
    strobe_set_t strobe_nxt;

    scd_cmd_decode #(
        .CMD_W    (CMD_W),
        .FLAG_BIT (FLAG_BIT),
        .OP_LSB   (OP_LSB),
        .OP_W     (OP_W),
        .SIZE_BIT (SIZE_BIT)
    ) u_decode (
        .cmd  (sys_cmd_i),
        .kind (kind)
    );

    scd_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (~cpu_valid_n_i),
        .req_kind   (kind),
        .rd_ready   (~rd_ready_n_i),
        .tag_match  (tag_match_i),
        .strobe_nxt (strobe_nxt)
    );

    scd_strobe_out u_out (
        .clk        (clk),
        .rst        (rst),
        .strobe_nxt (strobe_nxt),
        .hit_n      (hit_n_o),
        .rel_n      (bus_release_n_o),
        .fwd_n      (fwd_valid_n_o)
    );

endmodule

// File: tb/sim_scd_read_dispatch.sv
`timescale 1ns/1ps
module sim_scd_read_dispatch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] cmd = '0;
    logic       vo_n = 1'b1;
    logic       rdy_n = 1'b1;
    logic       tag = 1'b0;
    logic       hit_n, fwd_n, rel_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scd_read_dispatch u0 (
        .clk             (clk),
        .rst             (rst),
        .sys_cmd_i       (cmd),
        .cpu_valid_n_i   (vo_n),
        .rd_ready_n_i    (rdy_n),
        .tag_match_i     (tag),
        .hit_n_o         (hit_n),
        .fwd_valid_n_o   (fwd_n),
        .bus_release_n_o (rel_n)
    );

    // Compare {hit_n, rel_n, fwd_n} with the expected levels.
    task automatic check_out(input logic [2:0] exp, input string req, input int cyc);
        logic [2:0] act;
        act = {hit_n, rel_n, fwd_n};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d cmd=%h: {hit_n,rel_n,fwd_n} actual=%b expected=%b",
                     req, cyc, cmd, act, exp);
        end
    endtask

    task automatic idle_inputs();
        vo_n  = 1'b1;
        rdy_n = 1'b1;
        tag   = 1'b0;
        cmd   = '0;
    endtask

    // One request with issue at cycle k and tag outcome m; check 10 cycles.
    task automatic run_req(input logic [8:0] c_val, input int k, input logic m);
        bit    is_rd, part;
        string req;
        is_rd = (c_val[8] == 1'b0) && (c_val[7:5] == 3'b000);
        part  = c_val[3];
        if (!is_rd)    req = "R2";
        else if (part) req = "R3 R4";
        else           req = "R5 R6 R7 R8";
        for (int c = 0; c < 10; c++) begin
            logic [2:0] exp;
            @(negedge clk);
            vo_n  = (c <= k) ? 1'b0 : 1'b1;
            cmd   = c_val;
            rdy_n = (c == k) ? 1'b0 : 1'b1;
            tag   = (c == 1) ? m : ~m;   // R5: wrong value outside lookup
            exp = 3'b111;
            if (is_rd && part) begin
                if (c == k + 1) exp[0] = 1'b0;
            end else if (is_rd) begin
                if (c == k + 2) exp[1] = 1'b0;
                if (m && c >= 2 && c <= k + 2) exp[2] = 1'b0;
                if (!m && c == k + 3) exp[0] = 1'b0;
            end
            check_out(exp, req, c);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_out(3'b111, "R1 reset", 0);
        rst = 1'b0;
        @(negedge clk);
        check_out(3'b111, "R1 idle", 1);

        // Sweep every command code, read-ready delay and tag outcome.
        for (int d = 0; d < 4; d++)
            for (int m = 0; m < 2; m++)
                for (int cv = 0; cv < 512; cv++)
                    run_req(9'(cv), d, m[0]);

        // R9: block miss (issue cycle 0); partial read offered while busy.
        for (int c = 0; c < 10; c++) begin
            logic [2:0] exp;
            @(negedge clk);
            exp = 3'b111;
            if (c == 0) begin
                vo_n = 1'b0; cmd = 9'h000; rdy_n = 1'b0; tag = 1'b1;
            end else if (c <= 3) begin
                vo_n = 1'b0; cmd = 9'h008; rdy_n = 1'b0; tag = (c == 1) ? 1'b0 : 1'b1;
            end else begin
                idle_inputs();
            end
            if (c == 2) exp[1] = 1'b0;
            if (c == 3) exp[0] = 1'b0;
            check_out(exp, "R9 busy miss", c);
        end

        // R9: block miss, partial read accepted at issue+4.
        for (int c = 0; c < 9; c++) begin
            logic [2:0] exp;
            @(negedge clk);
            idle_inputs();
            exp = 3'b111;
            if (c == 0) begin vo_n = 1'b0; rdy_n = 1'b0; end
            if (c == 1) tag = 1'b0;
            if (c == 4) begin vo_n = 1'b0; cmd = 9'h008; rdy_n = 1'b0; end
            if (c == 2) exp[1] = 1'b0;
            if (c == 3 || c == 5) exp[0] = 1'b0;
            check_out(exp, "R9 after miss", c);
        end

        // R9: block hit, partial read accepted at issue+3.
        for (int c = 0; c < 8; c++) begin
            logic [2:0] exp;
            @(negedge clk);
            idle_inputs();
            exp = 3'b111;
            if (c == 0) begin vo_n = 1'b0; rdy_n = 1'b0; end
            if (c == 1) tag = 1'b1;
            if (c == 3) begin vo_n = 1'b0; cmd = 9'h008; rdy_n = 1'b0; end
            if (c == 2) begin exp[2] = 1'b0; exp[1] = 1'b0; end
            if (c == 4) exp[0] = 1'b0;
            check_out(exp, "R9 after hit", c);
        end

        // R9: partial read, next partial accepted at issue+2.
        for (int c = 0; c < 6; c++) begin
            logic [2:0] exp;
            @(negedge clk);
            idle_inputs();
            exp = 3'b111;
            if (c == 0 || c == 1 || c == 2) begin vo_n = 1'b0; cmd = 9'h008; rdy_n = 1'b0; end
            if (c == 1 || c == 3) exp[0] = 1'b0;
            check_out(exp, "R9 partial pair", c);
        end

        // R1: reset during a block hit with late read-ready.
        for (int c = 0; c < 8; c++) begin
            logic [2:0] exp;
            @(negedge clk);
            idle_inputs();
            rst = 1'b0;
            exp = 3'b111;
            if (c == 0) vo_n = 1'b0;
            if (c == 1) begin vo_n = 1'b0; tag = 1'b1; end
            if (c == 2) begin vo_n = 1'b0; rst = 1'b1; end
            if (c == 4) begin vo_n = 1'b0; cmd = 9'h008; rdy_n = 1'b0; end
            if (c == 2) exp[2] = 1'b0;
            if (c == 5) exp[0] = 1'b0;
            check_out(exp, "R1 mid-read reset", c);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule